// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block controls a port of 32 general-purpose pins through a small word-wide register bus. Every register holds one bit per pin. Each pin is either handed to a peripheral, which then drives the pad output and output-enable directly, or kept under software control. Under software control the pin drives its pad only when two independent settings agree: the input-mode bit must be cleared and the drive-enable bit must be set. The pad input of every pin is passed through a two-flop synchronizer. The synchronized level can be read back over the bus and is also brought out as a port for downstream event logic.

The bus is a single-cycle strobe interface. A write lands in the addressed register on the clock edge where `bus_valid` and `bus_write` are high. A read returns its word on `bus_rdata` one cycle after the strobe. The raw pad inputs are also forwarded to the peripheral side without change.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the handoff register (offset 0x00) and the input-mode register (offset 0x04) read all ones. The drive-enable register (0x08) and the output-level register (0x0C) read all zeros. With these values every pin is handed to the peripheral.
- R2: A write to offset 0x00, 0x04, 0x08 or 0x0C replaces the whole 32-bit register on that clock edge. A read with `bus_valid`=1 and `bus_write`=0 presents the register value on `bus_rdata` in the following cycle. `bus_rdata` is 0 in any cycle that does not follow a read strobe.
- R3: When a pin's handoff bit (offset 0x00, bit i for pin i) is 1, `pad_out[i]` equals `periph_out[i]` and `pad_oe[i]` equals `periph_oe[i]`, whatever the other registers hold.
- R4: When a pin's handoff bit is 0, `pad_out[i]` equals bit i of the output-level register. `pad_oe[i]` is 1 exactly when input-mode bit i is 0 (0 = output, 1 = input) and drive-enable bit i is 1.
- R5: For a pin under software control, clearing only its input-mode bit, or setting only its drive-enable bit, leaves `pad_oe[i]` at 0.
- R6: `pin_level` and a read of offset 0x10 show the value `pad_in` had two rising clock edges earlier. `periph_in` equals `pad_in` with no delay.
- R7: A write to the read-only offset 0x10, or to any offset other than 0x00, 0x04, 0x08 and 0x0C (including unaligned ones), changes no register. This is seen both in later reads and at the pad outputs.
- R8: A read of any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Transaction strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| pad_in | input | 32 | Asynchronous level from each pad |
| pad_out | output | 32 | Output level toward each pad |
| pad_oe | output | 32 | Output enable toward each pad |
| periph_out | input | 32 | Peripheral output level per pin |
| periph_oe | input | 32 | Peripheral output enable per pin |
| periph_in | output | 32 | Raw pad level forwarded to the peripheral |
| pin_level | output | 32 | Synchronized pad level |

## Verification
The assertions assume that `bus_valid` and `bus_write` are never unknown. They also assume that each strobe is a complete access within one cycle, so no write data is held over to a later edge. The synchronizer check assumes `pad_in` is sampled at clock edges and holds no X. Because the check counts edges only from reset release, stimulus may toggle the pads freely once reset is released. The bench keeps to these assumptions: it changes every input on the falling edge, it uses single-cycle strobes with idle cycles between them, and it uses fully defined random values for the pad and peripheral vectors.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned NUM_RW = 4;

  localparam logic [31:0] OFS_HANDOFF = 32'h00;
  localparam logic [31:0] OFS_INMODE  = 32'h04;
  localparam logic [31:0] OFS_DRIVE   = 32'h08;
  localparam logic [31:0] OFS_LEVEL   = 32'h0C;
  localparam logic [31:0] OFS_SAMPLE  = 32'h10;

  typedef enum logic [2:0] {
    SEL_HANDOFF = 3'd0,
    SEL_INMODE  = 3'd1,
    SEL_DRIVE   = 3'd2,
    SEL_LEVEL   = 3'd3,
    SEL_SAMPLE  = 3'd4,
    SEL_NONE    = 3'd7
  } reg_sel_e;

  // Map a byte offset onto a register select; anything else is unmapped.
  function automatic reg_sel_e decode_offset(input logic [31:0] ofs);
    case (ofs)
      OFS_HANDOFF: return SEL_HANDOFF;
      OFS_INMODE:  return SEL_INMODE;
      OFS_DRIVE:   return SEL_DRIVE;
      OFS_LEVEL:   return SEL_LEVEL;
      OFS_SAMPLE:  return SEL_SAMPLE;
      default:     return SEL_NONE;
    endcase
  endfunction

  // Software drives a pad only with output mode (0) and drive enabled.
  function automatic logic sw_drives(input logic in_mode, input logic drive_en);
    return (!in_mode) && drive_en;
  endfunction

  // Reset value of writable register k: handoff and input-mode start set.
  function automatic logic rw_reset_bit(input int unsigned k);
    return (k == 0) || (k == 1);
  endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS   = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  input  logic [PINS-1:0]   sample_lvl,
  output logic [PINS-1:0]   handoff,
  output logic [PINS-1:0]   in_mode,
  output logic [PINS-1:0]   drive_en,
  output logic [PINS-1:0]   out_level,
  output logic [PINS-1:0]   bus_rdata
);

  localparam int unsigned NREG = NUM_RW;

  reg_sel_e          sel;
  logic [NREG-1:0]   wr_hit;
  logic              any_wr_hit;
  logic              rd_strobe;
  logic              wr_strobe;
  logic [PINS-1:0]   regs_q [NREG];
  logic [PINS-1:0]   rd_word;
  logic [PINS-1:0]   rdata_q;
  logic [NREG*PINS-1:0] regs_flat;

  assign sel        = decode_offset(32'(bus_addr));
  assign rd_strobe  = bus_valid && !bus_write;
  assign wr_strobe  = bus_valid && bus_write;
  assign any_wr_hit = |wr_hit;

  for (genvar k = 0; k < NREG; k++) begin : g_rw
    assign wr_hit[k] = wr_strobe && (sel == reg_sel_e'(3'(k)));
    assign regs_flat[k*PINS +: PINS] = regs_q[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs_q[k] <= {PINS{rw_reset_bit(k)}};
      else if (wr_hit[k]) regs_q[k] <= bus_wdata;
    end

    // A mapped write lands whole on its edge
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[k] |=> (regs_q[k] == $past(bus_wdata)));
  end

  assign handoff   = regs_q[0];
  assign in_mode   = regs_q[1];
  assign drive_en  = regs_q[2];
  assign out_level = regs_q[3];

  always_comb begin
    case (sel)
      SEL_HANDOFF: rd_word = regs_q[0];
      SEL_INMODE:  rd_word = regs_q[1];
      SEL_DRIVE:   rd_word = regs_q[2];
      SEL_LEVEL:   rd_word = regs_q[3];
      SEL_SAMPLE:  rd_word = sample_lvl;
      default:     rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (rd_strobe) rdata_q <= rd_word;
    else                rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;

  // Writes that miss every writable register leave all state untouched
  assert_ignored_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !any_wr_hit) |=> $stable(regs_flat));

  // Unmapped reads return zero
  assert_unmapped_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && sel == SEL_NONE) |=> (bus_rdata == '0));

  // No strobe, no data
  assert_idle_rdata_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> (bus_rdata == '0));

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] level
);

  logic [PINS-1:0] meta_q;
  logic [PINS-1:0] stable_q;
  logic [1:0]      edges_q;
  logic            settled;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i]   <= 1'b0;
        stable_q[i] <= 1'b0;
      end else begin
        meta_q[i]   <= pad_in[i];
        stable_q[i] <= meta_q[i];
      end
    end
  end

  assign level = stable_q;

  // Edges since reset, saturating, so the latency check never reaches before reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             edges_q <= 2'd0;
    else if (edges_q != 2'd2) edges_q <= edges_q + 2'd1;
  end
  assign settled = (edges_q == 2'd2);

  assert_two_edge_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (level == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_port_padmux.sv
module gpio_port_padmux
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic [PINS-1:0] handoff,
  input  logic [PINS-1:0] in_mode,
  input  logic [PINS-1:0] drive_en,
  input  logic [PINS-1:0] out_level,
  input  logic [PINS-1:0] periph_out,
  input  logic [PINS-1:0] periph_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic sw_oe;
    assign sw_oe     = sw_drives(in_mode[i], drive_en[i]);
    assign pad_out[i] = handoff[i] ? periph_out[i] : out_level[i];
    assign pad_oe[i]  = handoff[i] ? periph_oe[i]  : sw_oe;
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int unsigned PINS   = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  input  logic [PINS-1:0]   periph_out,
  input  logic [PINS-1:0]   periph_oe,
  output logic [PINS-1:0]   periph_in,
  output logic [PINS-1:0]   pin_level
);

  logic [PINS-1:0] handoff;
  logic [PINS-1:0] in_mode;
  logic [PINS-1:0] drive_en;
  logic [PINS-1:0] out_level;
  logic [PINS-1:0] synced;

  gpio_port_sync #(.PINS(PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in (pad_in),
    .level  (synced)
  );

  gpio_port_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .sample_lvl (synced),
    .handoff    (handoff),
    .in_mode    (in_mode),
    .drive_en   (drive_en),
    .out_level  (out_level),
    .bus_rdata  (bus_rdata)
  );

  gpio_port_padmux #(.PINS(PINS)) u_mux (
    .handoff    (handoff),
    .in_mode    (in_mode),
    .drive_en   (drive_en),
    .out_level  (out_level),
    .periph_out (periph_out),
    .periph_oe  (periph_oe),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
  );

  assign periph_in = pad_in;
  assign pin_level = synced;

  // A software pin never drives unless both settings agree
  assert_no_half_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~handoff) & pad_oe & (in_mode | ~drive_en)) == '0);

  // Handed-off pins mirror the peripheral
  assert_handoff_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (handoff & ((pad_oe ^ periph_oe) | (pad_out ^ periph_out))) == '0);

  // Software pins present the stored output level
  assert_sw_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~handoff) & (pad_out ^ out_level)) == '0);

endmodule

// File: tb/tb_gpio_port_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic [31:0] periph_out = '0;
  logic [31:0] periph_oe = '0;
  logic [31:0] periph_in, pin_level;

  always #4 clk = ~clk;

  gpio_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .periph_in(periph_in), .pin_level(pin_level)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cycles   = 0;
  string tag      = "R1";

  // Behavioural reference model
  logic [31:0] m_hand, m_mode, m_drv, m_lvl;
  logic [31:0] m_s1, m_s2, m_rdata;

  function automatic logic [31:0] m_read(input int a);
    if (a == 0)  return m_hand;
    if (a == 4)  return m_mode;
    if (a == 8)  return m_drv;
    if (a == 12) return m_lvl;
    if (a == 16) return m_s2;
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hand = '1; m_mode = '1; m_drv = '0; m_lvl = '0;
      m_s1 = '0; m_s2 = '0; m_rdata = '0;
    end else begin
      m_rdata = (bus_valid && !bus_write) ? m_read(int'(bus_addr)) : 32'h0;
      if (bus_valid && bus_write) begin
        case (int'(bus_addr))
          0:  m_hand = bus_wdata;
          4:  m_mode = bus_wdata;
          8:  m_drv  = bus_wdata;
          12: m_lvl  = bus_wdata;
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
  end

  task automatic check(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  // Compare against the model every cycle, after falling-edge drives settle
  always @(negedge clk) begin
    #1;
    check(tag, "pad_out", pad_out, (m_hand & periph_out) | (~m_hand & m_lvl));
    check(tag, "pad_oe", pad_oe, (m_hand & periph_oe) | (~m_hand & ~m_mode & m_drv));
    check(tag, "bus_rdata", bus_rdata, m_rdata);
    check("R6", "pin_level", pin_level, m_s2);
    check("R6", "periph_in", periph_in, pad_in);
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    idle(1);
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    idle(1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  initial begin
    // R1: reset values, read back after release
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C); rd(8'h10);

    // R3: peripheral owns every pin while handed off
    tag = "R3";
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      periph_out = $urandom(); periph_oe = $urandom();
    end
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h04, 32'h0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      periph_out = $urandom(); periph_oe = $urandom();
    end
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h08, 32'h0);

    // R5: release lower half, then set only one drive condition at a time
    tag = "R5";
    wr(8'h00, 32'hFFFF_0000);
    wr(8'h0C, 32'h0000_A5A5);
    wr(8'h08, 32'h0000_FFFF);
    idle(2);
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h0);
    idle(2);

    // R4: both conditions met, then mixed patterns
    tag = "R4";
    wr(8'h08, 32'h0000_00FF);
    for (int i = 0; i < 12; i++) begin
      wr(8'h00, $urandom());
      wr(8'h04, $urandom());
      wr(8'h08, $urandom());
      wr(8'h0C, $urandom());
      @(negedge clk);
      periph_out = $urandom(); periph_oe = $urandom();
    end

    // R2: write and read back every writable register
    tag = "R2";
    for (int i = 0; i < 8; i++) begin
      for (int a = 0; a < 16; a += 4) begin
        wr(8'(a), $urandom());
        rd(8'(a));
      end
    end
    // back-to-back reads
    @(negedge clk); bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h04;
    @(negedge clk); bus_addr = 8'h08;
    @(negedge clk); bus_addr = 8'h0C;
    idle(2);

    // R7: writes to read-only, unmapped and unaligned offsets
    tag = "R7";
    wr(8'h00, 32'h0F0F_0F0F); wr(8'h04, 32'h3333_0000);
    wr(8'h08, 32'h00FF_FF00); wr(8'h0C, 32'hCAFE_F00D);
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'h1234_5678);
    wr(8'h02, 32'h0);         wr(8'hFC, 32'hFFFF_FFFF);
    wr(8'h01, 32'hDEAD_BEEF); wr(8'h40, 32'h0);
    idle(2);
    rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C);

    // R8: unmapped reads give zero
    tag = "R8";
    rd(8'h14); rd(8'h3C); rd(8'h01); rd(8'hFF); rd(8'h0E);

    // R6: synchronizer latency and sampled read
    tag = "R6";
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      pad_in = $urandom();
      if (i % 3 == 0) begin
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h10;
      end else begin
        bus_valid = 1'b0;
      end
    end
    idle(4);
    summary();
  end

endmodule